// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block registers the address and command bus of a memory module on the rising edge of the clock. It runs in one of two width modes. In the wide mode each data input feeds one output. In the fan-out mode a smaller set of inputs is captured, and each captured bit drives two identical output copies, A and B. A second configuration input picks which inputs form that smaller set. Both configuration inputs are static. They change only while reset is held.

The clock-enable, termination and chip-select inputs each have their own register. These registers load on every edge. The data registers load only when at least one of the two active-low select inputs is low. When both are high, the data outputs hold their values. An active-low reset acts asynchronously. It clears every register and drives every output low.

Top module: `cmd_buf_top`

## Requirements
- R1: With `cfg_fanout_i`=0 the block is in wide mode. On a rising edge, `q_a_o[k]` loads `d_i[k]` for every bit set in the wide mask 25'h1FFFFB6, which excludes bits 0, 3 and 6.
- R2: With `cfg_fanout_i`=1 and `cfg_alt_i`=0 the active bits are those of mask 25'h0003FB6 (bits 1, 2, 4, 5 and 7..13). Each active bit drives both `q_a_o[k]` and `q_b_o[k]`.
- R3: With `cfg_fanout_i`=1 and `cfg_alt_i`=1 the active bits are those of mask 25'h0001BBF (bits 0..5, 7..9, 11 and 12). Each active bit drives both copies.
- R4: Output bits outside the active mask read 0. In wide mode `q_b_o`, `cke_b_o`, `odt_b_o` and `cs_b_no` read 0.
- R5: The outputs change only at a rising clock edge. A change on an input between edges does not reach the outputs.
- R6: When `dcs_ni` and `csr_ni` are both 1 at an edge, `q_a_o` and `q_b_o` keep their values.
- R7: When `dcs_ni` or `csr_ni` is 0 at an edge, the data outputs load the new inputs.
- R8: `cke_a_o` and `odt_a_o` load `cke_i` and `odt_i` on every edge, whatever the select inputs are. In fan-out mode the B copies match them.
- R9: `cs_a_no` loads `dcs_ni` on every edge. In fan-out mode `cs_b_no` matches it.
- R10: `rst_ni`=0 drives all outputs to 0 at once, with no clock edge needed. The outputs stay 0 across edges while reset is held, whatever the select inputs are.
- R11: With `cfg_fanout_i`=0, the value of `cfg_alt_i` has no effect, and the block behaves as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fanout_i | input | 1 | 0 = wide 1:1 mode, 1 = 1:2 fan-out mode |
| cfg_alt_i | input | 1 | Selects the fan-out input set (0 = first, 1 = second) |
| d_i | input | 25 | Data inputs |
| cke_i | input | 1 | Clock-enable input |
| odt_i | input | 1 | Termination-control input |
| dcs_ni | input | 1 | Chip-select input, active low |
| csr_ni | input | 1 | Second select input, active low |
| q_a_o | output | 25 | Registered data, A copy |
| q_b_o | output | 25 | Registered data, B copy (fan-out mode only) |
| cke_a_o | output | 1 | Registered clock enable, A copy |
| cke_b_o | output | 1 | Registered clock enable, B copy |
| odt_a_o | output | 1 | Registered termination control, A copy |
| odt_b_o | output | 1 | Registered termination control, B copy |
| cs_a_no | output | 1 | Registered chip select, A copy |
| cs_b_no | output | 1 | Registered chip select, B copy |

## Verification
The assertions take the configuration inputs to be constant between resets. The masking and mirroring checks depend on this, because a mode change while running would leave stale bits in the registers. The bench changes `cfg_fanout_i` and `cfg_alt_i` only while `rst_ni` is low. It drives every data and select input at the falling clock edge, so the inputs stay stable around each capture edge. Reset is asserted and released away from the rising edge. This keeps the asynchronous clear and the first capture after release unambiguous.

// File: rtl/cmd_buf_pkg.sv
package cmd_buf_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE  = 2'd0,
    MODE_FAN_A = 2'd1,
    MODE_FAN_B = 2'd2
  } buf_mode_e;

  function automatic buf_mode_e mode_of(input logic fanout, input logic alt);
    if (!fanout) return MODE_WIDE;
    return alt ? MODE_FAN_B : MODE_FAN_A;
  endfunction
endpackage

// File: rtl/cmd_mode_decode.sv
module cmd_mode_decode
  import cmd_buf_pkg::*;
#(
  parameter int unsigned NUM_D = 25,
  parameter logic [NUM_D-1:0] MASK_WIDE  = 25'h1FFFFB6,
  parameter logic [NUM_D-1:0] MASK_FAN_A = 25'h0003FB6,
  parameter logic [NUM_D-1:0] MASK_FAN_B = 25'h0001BBF
) (
  input  logic             cfg_fanout_i,
  input  logic             cfg_alt_i,
  output logic [NUM_D-1:0] mask_o,
  output logic             dual_o
);
  buf_mode_e mode;

  always_comb begin
    mode = mode_of(cfg_fanout_i, cfg_alt_i);
    unique case (mode)
      MODE_FAN_A: mask_o = MASK_FAN_A;
      MODE_FAN_B: mask_o = MASK_FAN_B;
      default:    mask_o = MASK_WIDE;
    endcase
    dual_o = (mode != MODE_WIDE);
  end
endmodule

// File: rtl/cmd_data_reg.sv
module cmd_data_reg #(
  parameter int unsigned NUM_D = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_D-1:0] d_i,
  input  logic [NUM_D-1:0] mask_i,
  input  logic             dcs_ni,
  input  logic             csr_ni,
  output logic [NUM_D-1:0] q_o
);
  logic load;
  assign load = ~(dcs_ni & csr_ni);

  for (genvar k = 0; k < NUM_D; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[k] <= 1'b0;
      else if (load) q_o[k] <= d_i[k] & mask_i[k];
    end
  end

  AST_HOLD_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcs_ni && csr_ni) |=> $stable(q_o)); // R6
  AST_LOAD_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dcs_ni && csr_ni) |=> (q_o == $past(d_i & mask_i))); // R7
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~mask_i) == '0); // R4
endmodule

// File: rtl/cmd_ctrl_reg.sv
module cmd_ctrl_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic odt_i,
  input  logic dcs_ni,
  output logic cke_o,
  output logic odt_o,
  output logic cs_no
);
  // Never gated by the select inputs.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o <= 1'b0;
      odt_o <= 1'b0;
      cs_no <= 1'b0;
    end else begin
      cke_o <= cke_i;
      odt_o <= odt_i;
      cs_no <= dcs_ni;
    end
  end

  AST_CKE_ODT_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cke_o == $past(cke_i)) && (odt_o == $past(odt_i))); // R8
  AST_CS_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cs_no == $past(dcs_ni))); // R9
endmodule

// File: rtl/cmd_buf_top.sv
module cmd_buf_top #(
  parameter int unsigned NUM_D = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_fanout_i,
  input  logic             cfg_alt_i,
  input  logic [NUM_D-1:0] d_i,
  input  logic             cke_i,
  input  logic             odt_i,
  input  logic             dcs_ni,
  input  logic             csr_ni,
  output logic [NUM_D-1:0] q_a_o,
  output logic [NUM_D-1:0] q_b_o,
  output logic             cke_a_o,
  output logic             cke_b_o,
  output logic             odt_a_o,
  output logic             odt_b_o,
  output logic             cs_a_no,
  output logic             cs_b_no
);
  logic [NUM_D-1:0] mask;
  logic             dual;
  logic             cke_q, odt_q, cs_q;

  cmd_mode_decode #(.NUM_D(NUM_D)) u_decode (
    .cfg_fanout_i (cfg_fanout_i),
    .cfg_alt_i    (cfg_alt_i),
    .mask_o       (mask),
    .dual_o       (dual)
  );

  cmd_data_reg #(.NUM_D(NUM_D)) u_data (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (d_i),
    .mask_i (mask),
    .dcs_ni (dcs_ni),
    .csr_ni (csr_ni),
    .q_o    (q_a_o)
  );

  cmd_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cke_i  (cke_i),
    .odt_i  (odt_i),
    .dcs_ni (dcs_ni),
    .cke_o  (cke_q),
    .odt_o  (odt_q),
    .cs_no  (cs_q)
  );

  assign cke_a_o = cke_q;
  assign odt_a_o = odt_q;
  assign cs_a_no = cs_q;
  // B copies only exist in fan-out mode.
  assign q_b_o   = dual ? q_a_o : '0;
  assign cke_b_o = dual & cke_q;
  assign odt_b_o = dual & odt_q;
  assign cs_b_no = dual & cs_q;

  AST_B_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_fanout_i |-> (q_b_o == q_a_o) && (cs_b_no == cs_a_no)); // R2
  AST_B_OFF_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_fanout_i |-> (q_b_o == '0) && !cke_b_o && !odt_b_o && !cs_b_no); // R4
  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (q_a_o == '0) && (q_b_o == '0) && !cke_a_o && !odt_a_o && !cs_a_no); // R10
endmodule

// File: tb/cmd_buf_top_tb_top.sv
module cmd_buf_top_tb_top;
  localparam int unsigned ND = 25;
  localparam logic [ND-1:0] M_WIDE = 25'h1FFFFB6;
  localparam logic [ND-1:0] M_FA   = 25'h0003FB6;
  localparam logic [ND-1:0] M_FB   = 25'h0001BBF;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic cfg_fanout_i = 1'b0, cfg_alt_i = 1'b0;
  logic [ND-1:0] d_i = '0;
  logic cke_i = 1'b0, odt_i = 1'b0, dcs_ni = 1'b1, csr_ni = 1'b1;
  logic [ND-1:0] q_a_o, q_b_o;
  logic cke_a_o, cke_b_o, odt_a_o, odt_b_o, cs_a_no, cs_b_no;

  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  cmd_buf_top #(.NUM_D(ND)) dut_i (.*);

  task automatic chk(input string tag, input logic [ND-1:0] act, input logic [ND-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Drive at a falling edge, then wait one full cycle to the next falling edge.
  task automatic step(input logic [ND-1:0] d, input logic cke, input logic odt,
                      input logic dcs, input logic csr);
    d_i = d; cke_i = cke; odt_i = odt; dcs_ni = dcs; csr_ni = csr;
    @(negedge clk_i);
  endtask

  task automatic set_mode(input logic fan, input logic alt);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    cfg_fanout_i = fan; cfg_alt_i = alt;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    chk("R10 reset q_a", q_a_o, '0);
    chk("R10 reset ctrl", {cke_a_o, odt_a_o, cs_a_no}, '0);
  endtask

  task automatic t_wide();
    logic [ND-1:0] v;
    set_mode(1'b0, 1'b0);
    v = 25'h1FFFFFF;
    step(v, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R1 wide all ones", q_a_o, v & M_WIDE);
    chk("R4 wide B off", q_b_o, '0);
    chk("R4 wide ctrl B off", {cke_b_o, odt_b_o, cs_b_no}, '0);
    v = 25'h0A5C3E9;
    step(v, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R1 wide pattern", q_a_o, v & M_WIDE);
    // R5: a mid-cycle change must not reach the outputs before the edge
    d_i = 25'h1555555;
    #5;
    chk("R5 no change before edge", q_a_o, v & M_WIDE);
    @(negedge clk_i);
    chk("R5 change after edge", q_a_o, 25'h1555555 & M_WIDE);
  endtask

  task automatic t_fan_a();
    logic [ND-1:0] v;
    set_mode(1'b1, 1'b0);
    v = 25'h1FFFFFF;
    step(v, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R2 fanA copy A", q_a_o, M_FA);
    chk("R2 fanA copy B", q_b_o, M_FA);
    chk("R8 fanA cke/odt B", {cke_b_o, odt_b_o}, 2'b11);
    chk("R9 fanA cs B", {cs_a_no, cs_b_no}, 2'b00);
    v = 25'h12345AB;
    step(v, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 fanA pattern", q_b_o, v & M_FA);
    chk("R9 fanA cs high", {cs_a_no, cs_b_no}, 2'b11);
  endtask

  task automatic t_fan_b();
    logic [ND-1:0] v;
    set_mode(1'b1, 1'b1);
    v = 25'h1FFFFFF;
    step(v, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 fanB copy A", q_a_o, M_FB);
    chk("R3 fanB copy B", q_b_o, M_FB);
    v = 25'h0F0F0F0;
    step(v, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 fanB pattern", q_a_o, v & M_FB);
    chk("R4 fanB unused zero", q_a_o & ~M_FB, '0);
  endtask

  task automatic t_gating();
    logic [ND-1:0] v1, v2;
    set_mode(1'b0, 1'b0);
    v1 = 25'h0C3A5F6;
    v2 = 25'h13C5A09;
    step(v1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 load dcs low", q_a_o, v1 & M_WIDE);
    step(v2, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R6 hold both high", q_a_o, v1 & M_WIDE);
    chk("R8 cke/odt update while held", {cke_a_o, odt_a_o}, 2'b11);
    chk("R9 cs tracks while held", cs_a_no, 1'b1);
    step(v2, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 hold second cycle", q_a_o, v1 & M_WIDE);
    chk("R8 cke/odt fall while held", {cke_a_o, odt_a_o}, 2'b00);
    step(v2, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 load csr low", q_a_o, v2 & M_WIDE);
  endtask

  task automatic t_async_reset();
    step(25'h1FFFFFF, 1'b1, 1'b1, 1'b1, 1'b0);
    #3;
    rst_ni = 1'b0;
    #1;
    chk("R10 async clear q", q_a_o, '0);
    chk("R10 async clear ctrl", {cke_a_o, odt_a_o, cs_a_no}, '0);
    @(negedge clk_i);
    chk("R10 reset beats select", q_a_o, '0);
    chk("R10 ctrl held low", {cke_a_o, odt_a_o, cs_a_no}, '0);
    rst_ni = 1'b1;
  endtask

  task automatic t_undef_mode();
    logic [ND-1:0] v;
    set_mode(1'b0, 1'b1);
    v = 25'h1FFFFFF;
    step(v, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R11 alt ignored in wide", q_a_o, M_WIDE);
    chk("R11 B off in wide", q_b_o, '0);
  endtask

  initial begin
    #5 rst_ni = 1'b0;
    @(negedge clk_i);
    t_reset_state();
    rst_ni = 1'b1;
    t_wide();
    t_fan_a();
    t_fan_b();
    t_gating();
    t_async_reset();
    t_undef_mode();
    report();
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end
endmodule